// File: doc/BRIEF.md
# Counter Range-Compare Interrupt Unit

This block keeps a signed pulse count and watches it against a table of eight programmable windows. Up and down pulses arrive from outside the clock domain. They are synchronized, turned into single-cycle events on their rising edges, and applied to the count unless a hold input is asserted. Each window has an inclusive lower bound, an inclusive upper bound, an 8-bit task number and a request enable.

On every scan strobe the unit compares the count with all eight windows at once and updates one in-range flag per window. The flags work as a plain status vector even when no requests are wanted. A window whose condition goes from unmet to met becomes pending, provided its enable is set. The unit hands out pending requests one per strobe, lowest table index first. A request stays pending until it is serviced, even if the count has left the window by then.

Writing a window through the table port resets that window's history. Its flag, its pending request and its remembered condition are all cleared, so the next strobe judges the new window from scratch.

Top module: `cnt_range_irq`

## Requirements
- R1: After reset the count is 0, all flags are 0, no request is issued, and every window holds the empty range lower 0 / upper -1 with its enable clear.
- R2: A rising edge on `cnt_up` adds 1 to the count, and a rising edge on `cnt_dn` subtracts 1. Edges on both inputs at once leave the count unchanged. A level that rises before clock edge k changes the count at edge k+2. The count is 32-bit two's complement.
- R3: While `cnt_hold` is 1 at the clock edge where a pulse would be applied, the pulse is dropped and the count keeps its value.
- R4: At each clock edge with `scan_stb` = 1, `met_flags[i]` takes the value (lower_i <= count <= upper_i). The comparison is signed and both bounds are inclusive. This happens whatever the window's enable is. Otherwise the flags change only through R8.
- R5: A window becomes pending only when its condition at a strobe is met and at its previous strobe was unmet. A window that stays met raises no further request.
- R6: Each strobe issues at most one request: the lowest-indexed pending window, counting windows that become pending at that same strobe. `req_valid` is high for exactly the one cycle after the strobe edge, with `req_task` equal to that window's task number.
- R7: A pending window stays pending until it is issued, even if its condition becomes unmet in the meantime.
- R8: A table write to window i clears its flag, its pending state and its remembered condition. A write and a strobe in the same cycle leave window i with flag 0 and no request.
- R9: Overlapping windows are evaluated independently, and any number of flags may be set together.
- R10: A window whose enable is 0 never becomes pending, but its flag is still updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up | input | 1 | Asynchronous up-count pulse |
| cnt_dn | input | 1 | Asynchronous down-count pulse |
| cnt_hold | input | 1 | Count hold (gate), 1 = ignore pulses |
| scan_stb | input | 1 | Scan-cycle strobe, one evaluation per high cycle |
| tbl_wr | input | 1 | Table write enable |
| tbl_idx | input | 3 | Window index to write |
| tbl_lo | input | 32 | Signed lower bound |
| tbl_hi | input | 32 | Signed upper bound |
| tbl_task | input | 8 | Task number |
| tbl_en | input | 1 | Request enable of the window |
| pv | output | 32 | Signed present count |
| met_flags | output | 8 | Per-window in-range flags |
| req_valid | output | 1 | One-cycle task request |
| req_task | output | 8 | Task number of the request |

## Verification
The bench targets the inclusive bounds with windows whose lower and upper limits equal the count. A design with a strict comparison would miss those flags and their requests. It drives a negative count against windows that straddle zero, which an unsigned comparator would fail to flag. It raises several windows in one strobe and lets a deferred one leave its range before it is served. A design that issued all requests at once, or dropped stale pending bits, would then produce the wrong queue of task numbers. It also writes a window in the same cycle as a strobe, clears the enable of a window that is still pending, and pulses while the hold input is asserted. These cases expose stale requests, requests from disabled windows and counts that move while held.

// File: rtl/rngcmp_pkg.sv
package rngcmp_pkg;
    localparam int unsigned NUM_RANGES = 8;
    localparam int unsigned VAL_W      = 32;
    localparam int unsigned TASK_W     = 8;
    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned IDX_W      = $clog2(NUM_RANGES);

    typedef logic [NUM_RANGES-1:0] rmask_t;

    typedef struct packed {
        logic signed [VAL_W-1:0] lo;
        logic signed [VAL_W-1:0] hi;
        logic [TASK_W-1:0]       task_id;
        logic                    en;
    } range_ent_t;

    // index of the lowest set bit (0 when none)
    function automatic logic [IDX_W-1:0] lowest_idx(input rmask_t m);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NUM_RANGES - 1; i >= 0; i--) begin
            if (m[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic rmask_t lowest_onehot(input rmask_t m);
        return m & (~m + rmask_t'(1));
    endfunction

    function automatic logic in_window(input range_ent_t e,
                                       input logic signed [VAL_W-1:0] v);
        return ($signed(e.lo) <= v) && (v <= $signed(e.hi));
    endfunction
endpackage

// File: rtl/rngcmp_counter.sv
module rngcmp_counter
    import rngcmp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    up_in,
    input  logic                    dn_in,
    input  logic                    hold,
    output logic signed [VAL_W-1:0] count
);
    logic [SYNC_DEPTH:0] up_sh;
    logic [SYNC_DEPTH:0] dn_sh;
    logic                up_ev;
    logic                dn_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_sh <= '0;
            dn_sh <= '0;
        end else begin
            up_sh <= {up_sh[SYNC_DEPTH-1:0], up_in};
            dn_sh <= {dn_sh[SYNC_DEPTH-1:0], dn_in};
        end
    end

    assign up_ev = up_sh[SYNC_DEPTH-1] & ~up_sh[SYNC_DEPTH];
    assign dn_ev = dn_sh[SYNC_DEPTH-1] & ~dn_sh[SYNC_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (!hold) begin
            if (up_ev && !dn_ev)      count <= count + 1;
            else if (dn_ev && !up_ev) count <= count - 1;
        end
    end
endmodule

// File: rtl/rngcmp_table.sv
module rngcmp_table
    import rngcmp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic signed [VAL_W-1:0] wr_lo,
    input  logic signed [VAL_W-1:0] wr_hi,
    input  logic [TASK_W-1:0]       wr_task,
    input  logic                    wr_en,
    output range_ent_t              ents [NUM_RANGES],
    output rmask_t                  wr_mask
);
    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_ent
        assign wr_mask[g] = wr && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g].lo      <= '0;
                ents[g].hi      <= '1;
                ents[g].task_id <= '0;
                ents[g].en      <= 1'b0;
            end else if (wr_mask[g]) begin
                ents[g].lo      <= wr_lo;
                ents[g].hi      <= wr_hi;
                ents[g].task_id <= wr_task;
                ents[g].en      <= wr_en;
            end
        end
    end
endmodule

// File: rtl/rngcmp_eval.sv
module rngcmp_eval
    import rngcmp_pkg::*;
(
    input  range_ent_t              ents [NUM_RANGES],
    input  logic signed [VAL_W-1:0] count,
    output rmask_t                  met,
    output rmask_t                  en_mask
);
    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
        assign met[g]     = in_window(ents[g], count);
        assign en_mask[g] = ents[g].en;
    end
endmodule

// File: rtl/rngcmp_arb.sv
module rngcmp_arb
    import rngcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  rmask_t            met,
    input  rmask_t            en_mask,
    input  rmask_t            wr_mask,
    input  range_ent_t        ents [NUM_RANGES],
    output rmask_t            flags,
    output logic              req_valid,
    output logic [TASK_W-1:0] req_task
);
    rmask_t prev_q;
    rmask_t pend_q;
    rmask_t rise;
    rmask_t pend_all;
    rmask_t grant;

    always_comb begin
        rise     = met & ~prev_q & en_mask;
        pend_all = (pend_q | rise) & ~wr_mask;
        grant    = lowest_onehot(pend_all);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= '0;
            pend_q    <= '0;
            flags     <= '0;
            req_valid <= 1'b0;
            req_task  <= '0;
        end else begin
            req_valid <= 1'b0;
            if (stb) begin
                flags  <= met & ~wr_mask;
                prev_q <= met & ~wr_mask;
                pend_q <= pend_all & ~grant;
                if (|pend_all) begin
                    req_valid <= 1'b1;
                    req_task  <= ents[lowest_idx(pend_all)].task_id;
                end
            end else begin
                flags  <= flags  & ~wr_mask;
                prev_q <= prev_q & ~wr_mask;
                pend_q <= pend_q & ~wr_mask;
            end
        end
    end
endmodule

// File: rtl/cnt_range_irq.sv
module cnt_range_irq
    import rngcmp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cnt_up,
    input  logic                    cnt_dn,
    input  logic                    cnt_hold,
    input  logic                    scan_stb,
    input  logic                    tbl_wr,
    input  logic [IDX_W-1:0]        tbl_idx,
    input  logic signed [VAL_W-1:0] tbl_lo,
    input  logic signed [VAL_W-1:0] tbl_hi,
    input  logic [TASK_W-1:0]       tbl_task,
    input  logic                    tbl_en,
    output logic signed [VAL_W-1:0] pv,
    output logic [NUM_RANGES-1:0]   met_flags,
    output logic                    req_valid,
    output logic [TASK_W-1:0]       req_task
);
    range_ent_t ents [NUM_RANGES];
    rmask_t     wr_mask;
    rmask_t     met;
    rmask_t     en_mask;

    rngcmp_counter u_cnt (
        .clk(clk), .rst(rst), .up_in(cnt_up), .dn_in(cnt_dn),
        .hold(cnt_hold), .count(pv)
    );

    rngcmp_table u_tbl (
        .clk(clk), .rst(rst), .wr(tbl_wr), .wr_idx(tbl_idx),
        .wr_lo(tbl_lo), .wr_hi(tbl_hi), .wr_task(tbl_task), .wr_en(tbl_en),
        .ents(ents), .wr_mask(wr_mask)
    );

    rngcmp_eval u_eval (
        .ents(ents), .count(pv), .met(met), .en_mask(en_mask)
    );

    rngcmp_arb u_arb (
        .clk(clk), .rst(rst), .stb(scan_stb), .met(met), .en_mask(en_mask),
        .wr_mask(wr_mask), .ents(ents), .flags(met_flags),
        .req_valid(req_valid), .req_task(req_task)
    );
endmodule

// File: rtl/rngcmp_chk.sv
module rngcmp_chk
    import rngcmp_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    scan_stb,
    input logic                    tbl_wr,
    input logic [IDX_W-1:0]        tbl_idx,
    input logic                    cnt_hold,
    input logic signed [VAL_W-1:0] pv,
    input logic [NUM_RANGES-1:0]   met_flags,
    input logic                    req_valid
);
    // R6
    req_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($past(scan_stb) && !$past(rst)));

    // R4
    flags_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(scan_stb) && !$past(tbl_wr)) |-> $stable(met_flags));

    // R8
    wr_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tbl_wr)) |-> !met_flags[$past(tbl_idx)]);

    // R3
    hold_freezes_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cnt_hold)) |-> $stable(pv));

    // R2
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pv == $past(pv)) || (pv == $past(pv) + 1) || (pv == $past(pv) - 1)));
endmodule

bind cnt_range_irq rngcmp_chk u_chk (
    .clk(clk), .rst(rst), .scan_stb(scan_stb), .tbl_wr(tbl_wr),
    .tbl_idx(tbl_idx), .cnt_hold(cnt_hold), .pv(pv),
    .met_flags(met_flags), .req_valid(req_valid)
);

// File: tb/cnt_range_irq_tb.sv
module cnt_range_irq_tb;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cnt_up = 1'b0, cnt_dn = 1'b0, cnt_hold = 1'b0;
    logic               scan_stb = 1'b0, tbl_wr = 1'b0, tbl_en = 1'b0;
    logic [2:0]         tbl_idx = '0;
    logic signed [31:0] tbl_lo = '0, tbl_hi = '0;
    logic [7:0]         tbl_task = '0;
    logic signed [31:0] pv;
    logic [7:0]         met_flags;
    logic               req_valid;
    logic [7:0]         req_task;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    // bench model of the table and count
    logic signed [31:0] m_lo [8];
    logic signed [31:0] m_hi [8];
    logic signed [31:0] m_pv = 0;

    cnt_range_irq u_dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_flags();
        logic [7:0] f;
        for (int i = 0; i < 8; i++) f[i] = (m_lo[i] <= m_pv) && (m_pv <= m_hi[i]);
        return f;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && req_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected request", req_task, -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(req_task == e, "R6 request task", req_task, e);
            end
        end
    end

    task automatic wr(input int idx, input int lo, input int hi, input int tk, input bit en);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_idx = 3'(idx); tbl_lo = lo; tbl_hi = hi;
        tbl_task = 8'(tk); tbl_en = en;
        @(negedge clk);
        tbl_wr = 1'b0;
        m_lo[idx] = lo; m_hi[idx] = hi;
    endtask

    task automatic pulse(input bit up, input bit dn, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cnt_up = up; cnt_dn = dn;
            repeat (3) @(negedge clk);
            cnt_up = 1'b0; cnt_dn = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic strobe(input string tag);
        @(negedge clk);
        scan_stb = 1'b1;
        @(negedge clk);
        scan_stb = 1'b0;
        @(negedge clk);
        chk(exp_q.size() == 0, {tag, " requests drained"}, exp_q.size(), 0);
        chk(met_flags == exp_flags(), {tag, " flags"}, met_flags, exp_flags());
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = -1; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pv == 0, "R1 count after reset", pv, 0);
        chk(met_flags == 0, "R1 flags after reset", met_flags, 0);
        chk(req_valid == 0, "R1 no request after reset", req_valid, 0);
        strobe("R1 empty default windows");

        // R2 latency: rises before edge k, applied at edge k+2
        @(negedge clk); cnt_up = 1'b1;
        @(negedge clk); chk(pv == 0, "R2 latency edge1", pv, 0);
        @(negedge clk); chk(pv == 0, "R2 latency edge2", pv, 0);
        @(negedge clk); chk(pv == 1, "R2 latency edge3", pv, 1);
        cnt_up = 1'b0; repeat (3) @(negedge clk);
        pulse(1, 0, 4); m_pv = 5;
        chk(pv == 5, "R2 up count", pv, 5);
        pulse(0, 1, 3); m_pv = 2;
        chk(pv == 2, "R2 down count", pv, 2);
        pulse(1, 1, 2);
        chk(pv == 2, "R2 simultaneous up and down", pv, 2);

        // R3 hold
        cnt_hold = 1'b1;
        pulse(1, 0, 3);
        pulse(0, 1, 1);
        cnt_hold = 1'b0;
        @(negedge clk);
        chk(pv == 2, "R3 hold drops pulses", pv, 2);

        // table
        wr(0, 0, 10, 8'h11, 1);
        wr(1, 2, 2, 8'h22, 1);
        wr(2, 3, 20, 8'h33, 1);
        wr(3, -5, 1, 8'h44, 0);
        wr(5, 2, 2, 8'h55, 1);
        // R5 R6 R9: three windows rise together, served one per strobe
        exp_q.push_back(8'h11); strobe("R9 overlap pv=2");
        exp_q.push_back(8'h22); strobe("R6 second in order");
        exp_q.push_back(8'h55); strobe("R6 third in order");
        strobe("R5 no repeat while met");

        wr(4, -7, 3, 8'h66, 1);
        pulse(1, 0, 1); m_pv = 3;
        exp_q.push_back(8'h33); strobe("R4 inclusive lower pv=3");
        exp_q.push_back(8'h66); strobe("R4 inclusive upper pv=3");
        pulse(1, 0, 1); m_pv = 4;
        strobe("R4 above upper pv=4");

        // R7: pending window leaves its range before service
        pulse(0, 1, 2); m_pv = 2;
        exp_q.push_back(8'h22); strobe("R7 rises at pv=2");
        pulse(1, 0, 3); m_pv = 5;
        exp_q.push_back(8'h33); strobe("R7 new lower first");
        exp_q.push_back(8'h66); strobe("R7 stale pending kept");
        exp_q.push_back(8'h55); strobe("R7 last pending");
        strobe("R5 queue empty");

        // R10: disabled window flags but never requests
        pulse(0, 1, 4); m_pv = 1;
        exp_q.push_back(8'h66); strobe("R10 disabled window flagged");
        chk(met_flags[3] == 1'b1, "R10 disabled flag set", met_flags[3], 1);

        // R8: rewrite clears history
        wr(0, 0, 10, 8'h77, 1);
        chk(met_flags[0] == 1'b0, "R8 flag cleared by write", met_flags[0], 0);
        exp_q.push_back(8'h77); strobe("R8 fresh evaluation");
        wr(6, 0, 100, 8'h88, 1);
        wr(7, 0, 100, 8'h99, 1);
        exp_q.push_back(8'h88); strobe("R6 window6 first");
        wr(7, 0, 100, 8'h99, 0);
        strobe("R8 pending cleared by write");

        // R8: write in the same cycle as strobe
        @(negedge clk);
        tbl_wr = 1'b1; tbl_idx = 3'd6; tbl_lo = 0; tbl_hi = 100;
        tbl_task = 8'hAA; tbl_en = 1'b1; scan_stb = 1'b1;
        @(negedge clk);
        tbl_wr = 1'b0; scan_stb = 1'b0;
        @(negedge clk);
        chk(met_flags[6] == 1'b0, "R8 same-cycle write flag", met_flags[6], 0);
        exp_q.push_back(8'hAA); strobe("R8 after same-cycle write");

        // R4 signed comparison with a negative count
        pulse(0, 1, 3); m_pv = -2;
        chk(pv == -2, "R2 negative count", pv, -2);
        strobe("R4 signed pv=-2");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard empty at end", exp_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule